// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues clause-22 management transactions to an Ethernet PHY over the two-wire management interface. It drives the management clock, the data line and the data line's output enable, and it samples the returned data line. A host starts an operation with a one-cycle strobe and an operation code. The operation is either a synchronising preamble, a register read or a register write. PHY address, register address and write data are taken at the strobe. When the operation ends, the block pulses a done flag, and for a read it presents the 16-bit register value.

The management clock comes from the system clock through a programmable half-period divider. With the default setting and a 100 MHz system clock, the management clock runs at 2.5 MHz. Every bit is put on the line while the management clock is low and is held through the next rising edge. Input bits are sampled at the end of the low phase, just before the clock rises. A read sends a 16-bit command and then releases the line for 19 clocks. A write sends 32 bits and then releases the line for two clocks. The preamble is its own operation: 32 driven ones.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc, mdio_oe, busy and done are 0 and rdata is 0.
- R2: op 0 (sync) produces exactly 32 mdc rising edges, with mdio_oe=1 and mdio_o=1 at each one.
- R3: op 1 (read) produces 35 mdc rising edges. The first 16 are driven with the MSB-first bits 1,1,0,1,1,0, then phy_addr[4:0] MSB first, then reg_addr[4:0] MSB first. The remaining 19 have mdio_oe=0.
- R4: For a read, the 19 released clocks are sampled in order as s0..s18, and rdata is s2..s17 with s2 as bit 15. rdata holds this value from the cycle done is high.
- R5: op 2 (write) produces 34 mdc rising edges. The first 32 are driven MSB first with 0,1,0,1, then phy_addr, reg_addr, then 1,0, then wdata[15:0]. The last 2 have mdio_oe=0.
- R6: mdio_o and mdio_oe change only while mdc is low, so they are stable for the whole high phase.
- R7: Each half period of mdc lasts HALF_DIV system clocks, so rising edges are 2*HALF_DIV cycles apart. The default HALF_DIV=20 gives 2.5 MHz from 100 MHz.
- R8: busy is 1 from the cycle after an accepted start until the cycle in which done pulses. done is high for exactly one cycle, with busy low.
- R9: A start while busy is ignored and leaves the running frame unchanged. A start with op 3 is ignored and produces no mdc edge and no busy.
- R10: While the block is idle, mdc=0 and mdio_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 2 | 0 sync, 1 read, 2 write, 3 none |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Data from the last read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Most internal faults show up at the pins within one frame. A wrong bit index or a wrong shift-register load gives a wrong bit or a wrong edge count, visible at the first mdc rising edge it affects. A wrong drive-length boundary shows as mdio_oe high where the PHY should own the line, or low where it should not. A sampling phase that is off by one clock moves the read value by one bit, and that shows in rdata as soon as done pulses. Divider faults show in the spacing between the first two rising edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    OP_SYNC  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_NONE  = 2'd3
  } mdio_op_e;

  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 32;
  localparam int CNT_W   = 6;
  localparam int RD_IN   = 19;
  localparam int WR_TAIL = 2;
  localparam int RD_CMD  = 16;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= TOP;
    else if (cnt == '0) cnt <= TOP;
    else cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0) && !clr;

  // R7: the count never leaves its programmed range
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
  import mdio_pkg::*;
(
  input  logic [1:0]        op,
  input  logic [PHY_W-1:0]  phy_addr,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]  n_drive,
  output logic [CNT_W-1:0]  n_total,
  output logic              valid
);
  always_comb begin
    frame   = '0;
    n_drive = '0;
    n_total = '0;
    valid   = 1'b1;
    case (mdio_op_e'(op))
      OP_SYNC: begin
        frame   = '1;
        n_drive = CNT_W'(FRAME_W);
        n_total = CNT_W'(FRAME_W);
      end
      OP_READ: begin
        frame   = {2'b11, 2'b01, 2'b10, phy_addr, reg_addr, 16'h0000};
        n_drive = CNT_W'(RD_CMD);
        n_total = CNT_W'(RD_CMD + RD_IN);
      end
      OP_WRITE: begin
        frame   = {2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wdata};
        n_drive = CNT_W'(FRAME_W);
        n_total = CNT_W'(FRAME_W + WR_TAIL);
      end
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               is_rd,
  input  logic               frame_ok,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   n_drive,
  input  logic [CNT_W-1:0]   n_total,
  input  logic               tick,
  input  logic               mdio_i,
  output logic               accept,
  output logic [DATA_W-1:0]  rdata,
  output logic               busy,
  output logic               done,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe
);
  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_e;

  st_e                st;
  logic [FRAME_W-1:0] txsr;
  logic [RD_IN-1:0]   rxsr;
  logic [CNT_W-1:0]   idx, drv_len, tot_len;
  logic               rd_op;
  logic [CNT_W-1:0]   idx_nx;

  assign accept = start && frame_ok && (st == S_IDLE);
  assign idx_nx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; txsr <= '0; rxsr <= '0; idx <= '0;
      drv_len <= '0; tot_len <= '0; rd_op <= 1'b0;
      rdata <= '0; busy <= 1'b0; done <= 1'b0;
      mdc <= 1'b0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          txsr    <= frame;
          drv_len <= n_drive;
          tot_len <= n_total;
          rd_op   <= is_rd;
          idx     <= '0;
          rxsr    <= '0;
          mdio_o  <= frame[FRAME_W-1];
          mdio_oe <= 1'b1;
          busy    <= 1'b1;
          st      <= S_LOW;
        end
        S_LOW: if (tick) begin
          if (!mdio_oe) rxsr <= {rxsr[RD_IN-2:0], mdio_i};
          mdc <= 1'b1;
          st  <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          mdc <= 1'b0;
          if (idx == tot_len - 1'b1) begin
            st      <= S_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            if (rd_op) rdata <= rxsr[DATA_W:1];
          end else begin
            idx     <= idx_nx;
            txsr    <= {txsr[FRAME_W-2:0], 1'b0};
            mdio_o  <= (idx_nx < drv_len) ? txsr[FRAME_W-2] : 1'b0;
            mdio_oe <= (idx_nx < drv_len);
            st      <= S_LOW;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: done is seen with busy already low
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R8: an accepted start raises busy
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  // R6: line held during the high phase
  p_hold_high_r6: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R10: quiet line while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));
  // R7: the clock pin moves only on a divider tick
  p_edge_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (mdc != $past(mdc)) |-> $past(tick));
  // R9: a start while busy does not restart the frame
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && idx != '0) |=> (idx != '0));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   n_drive, n_total;
  logic               frame_ok, tick, accept;

  mdio_framer u_framer (
    .op(op), .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
    .frame(frame), .n_drive(n_drive), .n_total(n_total), .valid(frame_ok)
  );

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .clr(accept), .tick(tick)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst(rst), .start(start), .is_rd(op == 2'(OP_READ)),
    .frame_ok(frame_ok), .frame(frame), .n_drive(n_drive), .n_total(n_total),
    .tick(tick), .mdio_i(mdio_i), .accept(accept), .rdata(rdata),
    .busy(busy), .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int HD = 20;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] dat;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{2'd0, 5'd0,  5'd0,  16'h0000},
    '{2'd2, 5'd1,  5'd4,  16'h01E1},
    '{2'd1, 5'd1,  5'd2,  16'h2000},
    '{2'd2, 5'd31, 5'd31, 16'hFFFF},
    '{2'd1, 5'd17, 5'd10, 16'hA5C3},
    '{2'd1, 5'd0,  5'd0,  16'h0001}
  };

  logic clk = 0, rst = 1, start = 0;
  logic [1:0] op = 0;
  logic [4:0] phy_addr = 0, reg_addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic busy, done, mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0, fails = 0;
  int cyc = 0, nrise = 0, hold_err = 0, last_rise = 0, last_per = 0;
  logic prev_mdc = 0, h_o = 0, h_oe = 0, mon_clr = 0;
  logic rec_o [0:63];
  logic rec_oe [0:63];
  logic cur_rd = 0;
  logic [18:0] pat = '1;

  always #5 clk = ~clk;

  mdio_master #(.HALF_DIV(HD)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata), .busy(busy),
    .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = (cur_rd && nrise >= 16 && nrise < 35) ? pat[34-nrise] : 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_clr) begin
      nrise = 0; hold_err = 0;
    end else begin
      if (mdc && !prev_mdc) begin
        if (nrise < 64) begin rec_o[nrise] = mdio_o; rec_oe[nrise] = mdio_oe; end
        if (nrise > 0) last_per = cyc - last_rise;
        last_rise = cyc;
        h_o = mdio_o; h_oe = mdio_oe;
        nrise = nrise + 1;
      end else if (mdc && prev_mdc && (mdio_o != h_o || mdio_oe != h_oe))
        hold_err = hold_err + 1;
    end
    prev_mdc = mdc;
  end

  initial begin
    #1500000;
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_edges(input vec_t v);
    return (v.op == 2'd0) ? 32 : (v.op == 2'd1) ? 35 : 34;
  endfunction

  function automatic logic [1:0] exp_bit(input vec_t v, input int i);
    logic [31:0] w;
    if (v.op == 2'd0) return 2'b11;
    if (v.op == 2'd1) begin
      w = {2'b11, 2'b01, 2'b10, v.phy, v.rg, 16'h0};
      return (i < 16) ? {1'b1, w[31-i]} : 2'b00;
    end
    w = {2'b01, 2'b01, v.phy, v.rg, 2'b10, v.dat};
    return (i < 32) ? {1'b1, w[31-i]} : 2'b00;
  endfunction

  task automatic launch(input vec_t v);
    @(posedge clk); #1;
    mon_clr = 1;
    @(posedge clk); #1;
    mon_clr = 0;
    cur_rd = (v.op == 2'd1);
    pat = {1'b1, 1'b0, v.dat, 1'b1};
    op = v.op; phy_addr = v.phy; reg_addr = v.rg; wdata = v.dat;
    start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic finish_and_check(input vec_t v, input string req);
    int w = 0;
    int bad = 0;
    logic seen_busy_after_done;
    while (!done && w < 5000) begin @(posedge clk); #1; w = w + 1; end
    chk({"R8 done seen ", req}, done, 1);
    chk("R8 busy low with done", busy, 0);
    if (v.op == 2'd1) chk("R4 read data", rdata, v.dat);
    @(posedge clk); #1;
    seen_busy_after_done = busy;
    chk("R8 done single cycle", done, 0);
    chk("R10 idle quiet", {mdc, mdio_oe, seen_busy_after_done}, 0);
    chk({"edge count ", req}, nrise, exp_edges(v));
    for (int i = 0; i < exp_edges(v) && i < 64; i++)
      if ({rec_oe[i], rec_oe[i] ? rec_o[i] : 1'b0} != exp_bit(v, i)) bad = bad + 1;
    chk({"bit pattern ", req}, bad, 0);
    chk("R6 hold in high phase", hold_err, 0);
    chk("R7 mdc period", last_per, 2*HD);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 reset outputs", {mdc, mdio_oe, busy, done}, 0);
    chk("R1 reset rdata", rdata, 0);

    for (int k = 0; k < 6; k++) begin
      string tag;
      tag = (VEC[k].op == 2'd0) ? "R2" : (VEC[k].op == 2'd1) ? "R3" : "R5";
      launch(VEC[k]);
      chk("R8 busy after start", busy, 1);
      finish_and_check(VEC[k], tag);
    end

    // R9 start while busy is ignored
    launch(VEC[1]);
    repeat (300) @(posedge clk);
    #1;
    op = 2'd1; phy_addr = 5'd9; reg_addr = 5'd3; start = 1;
    @(posedge clk); #1;
    start = 0;
    finish_and_check(VEC[1], "R9 busy start");

    // R9 reserved op is ignored
    launch('{2'd3, 5'd1, 5'd1, 16'h1234});
    repeat (100) @(posedge clk);
    #1;
    chk("R9 op3 no busy", busy, 0);
    chk("R9 op3 no edges", nrise, 0);

    // R4 rdata kept across a write
    launch(VEC[3]);
    finish_and_check(VEC[3], "R5 second");
    chk("R4 rdata retained", rdata, VEC[5].dat);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule